// File: doc/BRIEF.md
# Scoreboard-Managed ALU Computation Unit

This unit couples an instruction issue stage, a scoreboard-controlled register file and a pipelined ALU. When it is idle and sees an issue pulse, it captures the opcode together with an operand-selection mask and a result-selection mask. It then collects each selected operand through its own read request/release handshake. It passes the opcode and operands to the ALU over a ready/valid channel and takes the ALU result back over a second ready/valid channel. Each selected result is written back through its own write request/release handshake, and the unit finishes with a single-cycle completion pulse.

None of these phases adds a wait state. Requests are raised in the issue cycle itself. A release, an ALU transfer, a result capture and a write release can all fall in one clock, so a fully ready environment completes an instruction in the cycle it is issued. Operands that are deselected, or that the opcode defines as zero, are never requested and reach the ALU as zero.

Top module: `cu_alu_unit`

## Requirements
- R1: An issue pulse is accepted only when `busy_o` is low. An issue pulse while busy has no effect: the opcode at `alu_op_o` and the operands stay those of the running instruction.
- R2: `busy_o` is low after reset. It goes high in the cycle after an accepted issue, unless that instruction completed in its issue cycle. It stays high up to and including the `done_o` cycle and is low in the cycle after it.
- R3: Bit i of `rd_req_o` is raised from the issue cycle for every required operand i. It stays high until `rd_rel_i[i]` is seen with it. The value on operand slot i of `rd_data_i` in that cycle is the value given to the ALU.
- R4: Operand i is required only when bit i of `src_mask_i` is 1. When bit OP_W-1 of the opcode is 1, operand 0 is treated as zero even if its mask bit is set. An operand that is not required is never requested and is presented to the ALU as zero.
- R5: `alu_valid_o` is high only when no required operand is still outstanding. This includes a release arriving in that same cycle. Once high, it holds with stable `alu_op_o` and `alu_src_o` until `alu_ready_i` is seen. It is low after the transfer.
- R6: `res_ready_o` is high only after the ALU transfer has happened and before a result has been captured. Exactly one result is captured per instruction.
- R7: Bit j of `wr_req_o` is raised for every result j selected by bit j of `dst_mask_i` from the capture cycle on. It holds until `wr_rel_i[j]` is seen with it. `wr_data_o` carries the captured ALU result.
- R8: `done_o` pulses for exactly one cycle when the last selected write is released, or when the result is captured if no result is selected. It stays low otherwise.
- R9: When every release, `alu_ready_i` and `res_valid_i` are already high, issue, fetch, ALU transfer, capture, write-back and `done_o` all happen in the issue cycle. `busy_o` then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue pulse |
| op_i | input | OP_W | Opcode to execute |
| src_mask_i | input | NUM_SRC | Operands the instruction reads |
| dst_mask_i | input | NUM_DST | Results the instruction writes |
| busy_o | output | 1 | Instruction in flight |
| done_o | output | 1 | Completion pulse |
| rd_req_o | output | NUM_SRC | Operand read requests |
| rd_rel_i | input | NUM_SRC | Operand read releases |
| rd_data_i | input | NUM_SRC*DATA_W | Operand data, slot i at bits i*DATA_W upward |
| alu_valid_o | output | 1 | ALU input valid |
| alu_ready_i | input | 1 | ALU input ready |
| alu_op_o | output | OP_W | Opcode to ALU |
| alu_src_o | output | NUM_SRC*DATA_W | Operands to ALU, same slot layout |
| res_valid_i | input | 1 | ALU result valid |
| res_ready_o | output | 1 | Unit can take the result |
| res_data_i | input | NUM_DST*DATA_W | ALU results, slot j at bits j*DATA_W upward |
| wr_req_o | output | NUM_DST | Result write requests |
| wr_rel_i | input | NUM_DST | Result write releases |
| wr_data_o | output | NUM_DST*DATA_W | Result data to register file |

## Verification
The unit is driven with staggered operand releases in a mixed order, so an early `alu_valid_o` is distinguishable from a correct one. A held-off `alu_ready_i` shows whether opcode and operands stay frozen. A partial operand mask combined with the zero-operand opcode bit separates masking from opcode-defined zeroes. A second issue pulse sent mid-flight shows whether a busy unit ignores it. An all-ready environment with every handshake high in the issue cycle exposes any stray wait state. An instruction with no results selected checks that completion follows directly from result capture.

// File: rtl/cu_pkg.sv
package cu_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_EXEC  = 2'd2,
    PH_WB    = 2'd3
  } cu_phase_e;

  function automatic logic [1:0] phase_code(logic busy, logic fired, logic got);
    if (!busy)      return PH_IDLE;
    else if (got)   return PH_WB;
    else if (fired) return PH_EXEC;
    else            return PH_FETCH;
  endfunction
endpackage

// File: rtl/cu_opnd_fetch.sv
module cu_opnd_fetch #(
  parameter int NUM_SRC = 3,
  parameter int DATA_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      busy_i,
  input  logic [NUM_SRC-1:0]        need_init_i,
  input  logic [NUM_SRC-1:0]        rel_i,
  input  logic [NUM_SRC*DATA_W-1:0] data_i,
  output logic [NUM_SRC-1:0]        req_o,
  output logic                      all_held_o,
  output logic [NUM_SRC*DATA_W-1:0] src_o
);
  logic [NUM_SRC-1:0] need_q;
  logic [NUM_SRC-1:0] need_cur;
  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] src_cur;

    always_comb begin
      if (busy_i)       need_cur[i] = need_q[i];
      else if (start_i) need_cur[i] = need_init_i[i];
      else              need_cur[i] = 1'b0;
      hit[i] = need_cur[i] & rel_i[i];
      if (hit[i])       src_cur = data_i[i*DATA_W +: DATA_W];
      else if (start_i) src_cur = '0;
      else              src_cur = src_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        need_q[i] <= 1'b0;
        src_q     <= '0;
      end else begin
        need_q[i] <= need_cur[i] & ~rel_i[i];
        src_q     <= src_cur;
      end
    end

    assign src_o[i*DATA_W +: DATA_W] = src_cur;
  end

  assign req_o      = need_cur;
  assign all_held_o = ~|(need_cur & ~hit);
endmodule

// File: rtl/cu_result_wb.sv
module cu_result_wb #(
  parameter int NUM_DST = 2,
  parameter int DATA_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cap_i,
  input  logic                      done_i,
  input  logic [NUM_DST-1:0]        dst_mask_i,
  input  logic [NUM_DST*DATA_W-1:0] res_data_i,
  input  logic [NUM_DST-1:0]        rel_i,
  output logic [NUM_DST-1:0]        req_o,
  output logic [NUM_DST*DATA_W-1:0] wr_data_o,
  output logic                      got_q_o,
  output logic                      got_o,
  output logic                      all_rel_o
);
  logic                      got_q;
  logic [NUM_DST-1:0]        pend_q;
  logic [NUM_DST-1:0]        pend_cur;
  logic [NUM_DST*DATA_W-1:0] data_q;

  always_comb begin
    if (got_q)      pend_cur = pend_q;
    else if (cap_i) pend_cur = dst_mask_i;
    else            pend_cur = '0;
  end

  for (genvar j = 0; j < NUM_DST; j++) begin : g_dst
    assign wr_data_o[j*DATA_W +: DATA_W] =
      got_q ? data_q[j*DATA_W +: DATA_W] : res_data_i[j*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_q  <= 1'b0;
      pend_q <= '0;
      data_q <= '0;
    end else begin
      got_q  <= (got_q | cap_i) & ~done_i;
      pend_q <= pend_cur & ~rel_i;
      if (cap_i) data_q <= res_data_i;
    end
  end

  assign req_o     = pend_cur;
  assign got_q_o   = got_q;
  assign got_o     = got_q | cap_i;
  assign all_rel_o = ~|(pend_cur & ~rel_i);
endmodule

// File: rtl/cu_alu_unit.sv
module cu_alu_unit #(
  parameter int NUM_SRC = 3,
  parameter int NUM_DST = 2,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      issue_i,
  input  logic [OP_W-1:0]           op_i,
  input  logic [NUM_SRC-1:0]        src_mask_i,
  input  logic [NUM_DST-1:0]        dst_mask_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [NUM_SRC-1:0]        rd_req_o,
  input  logic [NUM_SRC-1:0]        rd_rel_i,
  input  logic [NUM_SRC*DATA_W-1:0] rd_data_i,
  output logic                      alu_valid_o,
  input  logic                      alu_ready_i,
  output logic [OP_W-1:0]           alu_op_o,
  output logic [NUM_SRC*DATA_W-1:0] alu_src_o,
  input  logic                      res_valid_i,
  output logic                      res_ready_o,
  input  logic [NUM_DST*DATA_W-1:0] res_data_i,
  output logic [NUM_DST-1:0]        wr_req_o,
  input  logic [NUM_DST-1:0]        wr_rel_i,
  output logic [NUM_DST*DATA_W-1:0] wr_data_o
);
  import cu_pkg::*;

  localparam int ZERO_BIT = OP_W - 1;

  logic               busy_q;
  logic               fired_q;
  logic [OP_W-1:0]    op_q;
  logic [NUM_DST-1:0] dst_q;
  logic               issue_acc;
  logic               active;
  logic               alu_fire;
  logic               fired_eff;
  logic               res_cap;
  logic               all_held;
  logic               got_q;
  logic               got_eff;
  logic               all_rel;
  logic [NUM_SRC-1:0] need_init;
  logic [NUM_SRC-1:0] zero_mask;
  logic [NUM_DST-1:0] dst_cur;
  logic [1:0]         phase;

  assign issue_acc = issue_i & ~busy_q;
  assign active    = busy_q | issue_acc;

  always_comb begin
    zero_mask    = '0;
    zero_mask[0] = op_i[ZERO_BIT];
    need_init    = src_mask_i & ~zero_mask;
  end

  assign alu_op_o = busy_q ? op_q : op_i;
  assign dst_cur  = busy_q ? dst_q : dst_mask_i;

  cu_opnd_fetch #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
  ) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (issue_acc),
    .busy_i      (busy_q),
    .need_init_i (need_init),
    .rel_i       (rd_rel_i),
    .data_i      (rd_data_i),
    .req_o       (rd_req_o),
    .all_held_o  (all_held),
    .src_o       (alu_src_o)
  );

  assign alu_valid_o = active & ~fired_q & all_held;
  assign alu_fire    = alu_valid_o & alu_ready_i;
  assign fired_eff   = fired_q | alu_fire;
  assign res_ready_o = active & fired_eff & ~got_q;
  assign res_cap     = res_ready_o & res_valid_i;

  cu_result_wb #(
    .NUM_DST (NUM_DST),
    .DATA_W  (DATA_W)
  ) u_wb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (res_cap),
    .done_i     (done_o),
    .dst_mask_i (dst_cur),
    .res_data_i (res_data_i),
    .rel_i      (wr_rel_i),
    .req_o      (wr_req_o),
    .wr_data_o  (wr_data_o),
    .got_q_o    (got_q),
    .got_o      (got_eff),
    .all_rel_o  (all_rel)
  );

  assign done_o = active & got_eff & all_rel;
  assign busy_o = busy_q;
  assign phase  = phase_code(busy_q, fired_q, got_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      fired_q <= 1'b0;
      op_q    <= '0;
      dst_q   <= '0;
    end else begin
      busy_q  <= active & ~done_o;
      fired_q <= fired_eff & ~done_o;
      if (issue_acc) begin
        op_q  <= op_i;
        dst_q <= dst_mask_i;
      end
    end
  end
endmodule

// File: rtl/cu_alu_unit_chk.sv
module cu_alu_unit_chk #(
  parameter int NUM_SRC = 3,
  parameter int NUM_DST = 2,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      issue_i,
  input logic                      busy_o,
  input logic                      done_o,
  input logic [NUM_SRC-1:0]        rd_req_o,
  input logic [NUM_SRC-1:0]        rd_rel_i,
  input logic                      alu_valid_o,
  input logic                      alu_ready_i,
  input logic [OP_W-1:0]           alu_op_o,
  input logic [NUM_SRC*DATA_W-1:0] alu_src_o,
  input logic                      res_ready_o,
  input logic [NUM_DST-1:0]        wr_req_o,
  input logic [NUM_DST-1:0]        wr_rel_i
);
  a_r1_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !busy_o && !done_o |=> busy_o);

  a_r1_hold_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> $stable(alu_op_o));

  a_r2_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);

  a_r8_done_drops_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r5_valid_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_valid_o && !alu_ready_i |=> alu_valid_o && $stable(alu_op_o) && $stable(alu_src_o));

  a_r5_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_valid_o && alu_ready_i && !done_o |=> !alu_valid_o);

  a_r6_ready_after_alu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_ready_o |-> !alu_valid_o || alu_ready_i);

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !issue_i |-> !res_ready_o && !alu_valid_o && (rd_req_o == '0) && (wr_req_o == '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_rd
    a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_req_o[i] && !rd_rel_i[i] |=> rd_req_o[i]);
    a_r3_no_rerequest: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_req_o[i] && rd_rel_i[i] && !done_o |=> !rd_req_o[i]);
  end

  for (genvar j = 0; j < NUM_DST; j++) begin : g_wr
    a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_req_o[j] && !wr_rel_i[j] |=> wr_req_o[j]);
  end
endmodule

bind cu_alu_unit cu_alu_unit_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_DST (NUM_DST),
  .DATA_W  (DATA_W),
  .OP_W    (OP_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .issue_i     (issue_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rd_req_o    (rd_req_o),
  .rd_rel_i    (rd_rel_i),
  .alu_valid_o (alu_valid_o),
  .alu_ready_i (alu_ready_i),
  .alu_op_o    (alu_op_o),
  .alu_src_o   (alu_src_o),
  .res_ready_o (res_ready_o),
  .wr_req_o    (wr_req_o),
  .wr_rel_i    (wr_rel_i)
);

// File: tb/cu_alu_unit_tb_top.sv
module cu_alu_unit_tb_top;
  localparam int NS = 3;
  localparam int ND = 2;
  localparam int DW = 16;
  localparam int OW = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             issue_i = 1'b0;
  logic [OW-1:0]    op_i = '0;
  logic [NS-1:0]    src_mask_i = '0;
  logic [ND-1:0]    dst_mask_i = '0;
  logic             busy_o, done_o;
  logic [NS-1:0]    rd_req_o;
  logic [NS-1:0]    rd_rel_i = '0;
  logic [NS*DW-1:0] rd_data_i = '0;
  logic             alu_valid_o;
  logic             alu_ready_i = 1'b0;
  logic [OW-1:0]    alu_op_o;
  logic [NS*DW-1:0] alu_src_o;
  logic             res_valid_i = 1'b0;
  logic             res_ready_o;
  logic [ND*DW-1:0] res_data_i = '0;
  logic [ND-1:0]    wr_req_o;
  logic [ND-1:0]    wr_rel_i = '0;
  logic [ND*DW-1:0] wr_data_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  cu_alu_unit #(.NUM_SRC(NS), .NUM_DST(ND), .DATA_W(DW), .OP_W(OW)) dut_i (
    .clk_i, .rst_ni, .issue_i, .op_i, .src_mask_i, .dst_mask_i, .busy_o, .done_o,
    .rd_req_o, .rd_rel_i, .rd_data_i, .alu_valid_o, .alu_ready_i, .alu_op_o,
    .alu_src_o, .res_valid_i, .res_ready_o, .res_data_i, .wr_req_o, .wr_rel_i,
    .wr_data_o
  );

  // ALU stub: result 0 = sum of operands + op, result 1 = xor of operands
  function automatic logic [ND*DW-1:0] alu_model(logic [OW-1:0] op, logic [NS*DW-1:0] s);
    logic [DW-1:0] a, x;
    a = DW'(op);
    x = '0;
    for (int i = 0; i < NS; i++) begin
      a = a + s[i*DW +: DW];
      x = x ^ s[i*DW +: DW];
    end
    return {x, a};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance to next falling edge; inputs change here, checks follow #1
  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    #1;
    chk("R2 reset busy", 64'(busy_o), 0);
    chk("R8 reset done", 64'(done_o), 0);
    chk("R3 reset rd_req", 64'(rd_req_o), 0);
    chk("R5 reset valid", 64'(alu_valid_o), 0);
    chk("R7 reset wr_req", 64'(wr_req_o), 0);
  endtask

  task automatic t_staggered();
    logic [NS*DW-1:0] s;
    logic [ND*DW-1:0] r;
    s = {16'h0300, 16'h0020, 16'h0001};
    issue_i = 1; op_i = 8'h05; src_mask_i = 3'b111; dst_mask_i = 2'b11; #1;
    chk("R3 req in issue cycle", 64'(rd_req_o), 64'b111);
    chk("R2 busy low in issue cycle", 64'(busy_o), 0);
    tick(); issue_i = 0; rd_rel_i = 3'b010; rd_data_i = {16'hdead, s[DW +: DW], 16'hbeef}; #1;
    chk("R2 busy after issue", 64'(busy_o), 1);
    chk("R5 valid early", 64'(alu_valid_o), 0);
    tick(); rd_rel_i = 3'b101; rd_data_i = {s[2*DW +: DW], 16'h7777, s[0 +: DW]}; #1;
    chk("R3 req held", 64'(rd_req_o), 64'b101);
    chk("R5 valid with last release", 64'(alu_valid_o), 1);
    chk("R3 operands", 64'(alu_src_o), 64'(s));
    tick(); rd_rel_i = 0; rd_data_i = '0; #1;
    chk("R5 valid held", 64'(alu_valid_o), 1);
    chk("R5 operands held", 64'(alu_src_o), 64'(s));
    chk("R6 no ready before transfer", 64'(res_ready_o), 0);
    alu_ready_i = 1; #1;
    chk("R6 ready with transfer", 64'(res_ready_o), 1);
    r = alu_model(alu_op_o, alu_src_o);
    tick(); alu_ready_i = 0; #1;
    chk("R5 valid dropped", 64'(alu_valid_o), 0);
    chk("R6 ready waits", 64'(res_ready_o), 1);
    res_valid_i = 1; res_data_i = r; #1;
    chk("R7 wr_req at capture", 64'(wr_req_o), 64'b11);
    tick(); res_valid_i = 0; res_data_i = '0; wr_rel_i = 2'b01; #1;
    chk("R6 single capture", 64'(res_ready_o), 0);
    chk("R7 wr_data", 64'(wr_data_o), 64'(r));
    chk("R8 no early done", 64'(done_o), 0);
    tick(); wr_rel_i = 2'b10; #1;
    chk("R7 wr_req held", 64'(wr_req_o), 64'b10);
    chk("R8 done", 64'(done_o), 1);
    chk("R2 busy in done cycle", 64'(busy_o), 1);
    tick(); wr_rel_i = 0; #1;
    chk("R8 done one cycle", 64'(done_o), 0);
    chk("R2 busy dropped", 64'(busy_o), 0);
  endtask

  task automatic t_masked_zero();
    issue_i = 1; op_i = 8'h81; src_mask_i = 3'b011; dst_mask_i = 2'b01; #1;
    chk("R4 opcode zero and mask", 64'(rd_req_o), 64'b010);
    tick(); issue_i = 0; rd_rel_i = 3'b111; rd_data_i = {16'h1111, 16'h2222, 16'h3333}; #1;
    chk("R4 zero operands", 64'(alu_src_o), 64'({16'h0, 16'h2222, 16'h0}));
    alu_ready_i = 1;
    tick(); rd_rel_i = 0; alu_ready_i = 0; rd_data_i = '0;
    op_i = 8'h42; issue_i = 1; #1;
    chk("R1 issue ignored while busy", 64'(alu_op_o), 64'h81);
    chk("R1 no new requests", 64'(rd_req_o), 0);
    res_valid_i = 1; res_data_i = {16'haaaa, 16'h5555};
    tick(); issue_i = 0; res_valid_i = 0; #1;
    chk("R7 only selected result", 64'(wr_req_o), 64'b01);
    chk("R1 op unchanged", 64'(alu_op_o), 64'h81);
    wr_rel_i = 2'b01; #1;
    chk("R8 done masked", 64'(done_o), 1);
    tick(); wr_rel_i = 0; #1;
    chk("R2 idle after masked", 64'(busy_o), 0);
  endtask

  task automatic t_single_cycle();
    logic [NS*DW-1:0] s;
    s = {16'h0004, 16'h0030, 16'h0200};
    issue_i = 1; op_i = 8'h10; src_mask_i = 3'b111; dst_mask_i = 2'b11;
    rd_rel_i = 3'b111; rd_data_i = s; alu_ready_i = 1; res_valid_i = 1;
    res_data_i = alu_model(8'h10, s); wr_rel_i = 2'b11; #1;
    chk("R9 valid same cycle", 64'(alu_valid_o), 1);
    chk("R9 wr_data same cycle", 64'(wr_data_o), 64'(alu_model(8'h10, s)));
    chk("R9 done same cycle", 64'(done_o), 1);
    tick(); issue_i = 0; rd_rel_i = 0; alu_ready_i = 0; res_valid_i = 0; wr_rel_i = 0; #1;
    chk("R9 busy stays low", 64'(busy_o), 0);
    chk("R9 done once", 64'(done_o), 0);
  endtask

  task automatic t_no_result();
    issue_i = 1; op_i = 8'h03; src_mask_i = 3'b000; dst_mask_i = 2'b00; #1;
    chk("R4 no requests", 64'(rd_req_o), 0);
    chk("R5 valid without operands", 64'(alu_valid_o), 1);
    tick(); issue_i = 0; #1;
    chk("R5 valid holds", 64'(alu_valid_o), 1);
    alu_ready_i = 1;
    tick(); alu_ready_i = 0; res_valid_i = 1; #1;
    chk("R8 done on capture", 64'(done_o), 1);
    chk("R7 no writes", 64'(wr_req_o), 0);
    tick(); res_valid_i = 0; #1;
    chk("R2 idle", 64'(busy_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_staggered();
    tick();
    t_masked_zero();
    tick();
    t_single_cycle();
    tick();
    t_no_result();
    tick();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule